// File: doc/BRIEF.md
# Serial Converter Capture and Power Command Sequencer

This block drives a three-wire serial analog-to-digital converter from the host side. It owns two lines, a conversion-start strobe and a serial clock. It reads one line back, the converter's serial data. On a capture request it raises the start strobe for one time unit. It then waits a programmable setup interval and emits a burst of serial clock pulses. On each rising clock edge it samples the data line. The last thirteen samples of the burst form a word: a reference-ready flag followed by twelve data bits, most significant first.

The captured word is presented on a 16-bit result bus together with a one-cycle valid strobe. In plain format the ready flag sits in bit 12 and the bits above it are zero. When the converter runs in bipolar mode and signed output is selected, the twelve data bits are treated as two's complement and sign-extended instead. A capture whose ready flag came back low also raises a not-ready flag beside the valid strobe.

The same two lines carry power-state commands. Light power-down is two start pulses with the clock held low. Deep power-down is four such pulses. Wake-up is a single clock pulse with the start line low. Every operation is followed by a quiet interval. Requests that arrive while an operation runs are held and served afterwards in a fixed priority order.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the start line, serial clock, valid strobe and not-ready flag are low, and the result bus reads zero until the first capture completes.
- R2: A capture raises the start line for exactly one time unit (DIV_CYC clocks). It then holds both lines low for SETUP_UNITS units before the first clock rise.
- R3: A capture emits exactly FRAME_LEN serial clock pulses. Each low phase and each high phase lasts exactly one time unit.
- R4: The data line is sampled at each serial clock rise. Of the FRAME_LEN samples, the thirteenth from the end is the ready flag and the remaining twelve are data bits 11 down to 0, in that order.
- R5: In plain format the result is {3'b000, ready, data[11:0]}.
- R6: When both bipolar_i and sext_i are high at completion, the result is data[11:0] sign-extended to 16 bits. With sext_i high but bipolar_i low, plain format applies.
- R7: Completion raises the valid strobe for exactly one clock, in the clock after the last serial clock high phase ends. The not-ready flag is high in that same clock only if the ready sample was 0, and is low at all other times.
- R8: A light power-down request produces exactly two start pulses, each one unit high and one unit low, with the serial clock low throughout.
- R9: A deep power-down request produces exactly four such start pulses with the serial clock low throughout.
- R10: A wake request produces exactly one serial clock pulse, one unit high, with the start line low throughout.
- R11: Every operation ends with GAP_UNITS quiet units plus one idle clock before the next operation may begin. After deep power-down, the wake clock rises DIV_CYC*(1+GAP_UNITS)+1 clocks after the last start fall.
- R12: Requests arriving while an operation runs are held, not dropped. When several are pending the order of service is wake, then deep power-down, then light power-down, then capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_req | input | 1 | One-cycle request for a capture |
| nap_req | input | 1 | One-cycle request for light power-down |
| sleep_req | input | 1 | One-cycle request for deep power-down |
| wake_req | input | 1 | One-cycle request for wake-up |
| bipolar_i | input | 1 | Converter is in bipolar (two's complement) mode |
| sext_i | input | 1 | Select sign-extended output when bipolar |
| adc_dout | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Conversion-start / command strobe |
| adc_sclk | output | 1 | Serial clock to the converter |
| sample_o | output | 16 | Formatted captured word |
| sample_valid_o | output | 1 | One-cycle strobe when sample_o is updated |
| not_ready_o | output | 1 | With the strobe: ready flag was low |

## Verification
The embedded properties watch several rules on every clock. The start line and the serial clock are never high together. A wake operation never touches the start line. A pending request is never lost while the sequencer is busy. The valid strobe lasts a single clock and the not-ready flag only accompanies it. The upper result bits obey the selected format. The exact unit lengths, the pulse counts of each power command and the bit order of the captured frame can only be shown by the bench's scenarios. The same holds for the service order among held requests and the length of the quiet interval. There, a per-clock model of both output lines is compared against the design.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CONV_HI, S_CONV_LO, S_SETUP, S_CLK_LO, S_CLK_HI, S_WAKE_HI, S_GAP
  } seq_state_e;

  typedef enum logic [1:0] {OP_CAP, OP_NAP, OP_SLP, OP_WAKE} op_e;

  localparam int BIT_CAP  = 0;
  localparam int BIT_NAP  = 1;
  localparam int BIT_SLP  = 2;
  localparam int BIT_WAKE = 3;
  localparam int NREQ     = 4;

  localparam int NAP_PULSES = 2;
  localparam int SLP_PULSES = 4;

  localparam int DATA_BITS = 12;
  localparam int WORD_BITS = DATA_BITS + 1;
  localparam int OUT_BITS  = 16;
endpackage

// File: rtl/acc_tick_gen.sv
module acc_tick_gen #(
  parameter int DIV_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV_CYC > 2) ? $clog2(DIV_CYC) : 1;

  logic [DW-1:0] div_q, div_n;

  assign tick = run && (div_q == DW'(DIV_CYC - 1));

  always_comb begin
    if (!run || tick) div_n = '0;
    else              div_n = div_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  // Unit boundaries never come back to back (R3 unit length)
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int SETUP_UNITS = 2,
  parameter int GAP_UNITS   = 5,
  parameter int FRAME_LEN   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NREQ-1:0] req,
  output logic            run,
  output logic            conv_o,
  output logic            sclk_o,
  output logic            sample_en,
  output logic            frame_done
);
  localparam int M1   = (FRAME_LEN > SETUP_UNITS) ? FRAME_LEN : SETUP_UNITS;
  localparam int M2   = (GAP_UNITS > SLP_PULSES) ? GAP_UNITS : SLP_PULSES;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e      state_q, state_n;
  op_e             op_q, op_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [NREQ-1:0] pend_q, pend_n, launch;
  logic            conv_q, sclk_q;

  assign run    = (state_q != S_IDLE);
  assign conv_o = conv_q;
  assign sclk_o = sclk_q;

  always_comb begin
    state_n    = state_q;
    op_n       = op_q;
    cnt_n      = cnt_q;
    launch     = '0;
    sample_en  = 1'b0;
    frame_done = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (pend_q[BIT_WAKE]) begin
          launch[BIT_WAKE] = 1'b1; op_n = OP_WAKE; state_n = S_WAKE_HI;
        end else if (pend_q[BIT_SLP]) begin
          launch[BIT_SLP] = 1'b1; op_n = OP_SLP; state_n = S_CONV_HI;
          cnt_n = CW'(SLP_PULSES);
        end else if (pend_q[BIT_NAP]) begin
          launch[BIT_NAP] = 1'b1; op_n = OP_NAP; state_n = S_CONV_HI;
          cnt_n = CW'(NAP_PULSES);
        end else if (pend_q[BIT_CAP]) begin
          launch[BIT_CAP] = 1'b1; op_n = OP_CAP; state_n = S_CONV_HI;
          cnt_n = CW'(1);
        end
      end
      S_CONV_HI: if (tick) begin
        if (op_q == OP_CAP) begin
          state_n = S_SETUP; cnt_n = CW'(SETUP_UNITS - 1);
        end else begin
          state_n = S_CONV_LO;
        end
      end
      S_CONV_LO: if (tick) begin
        if (cnt_q == CW'(1)) begin
          state_n = S_GAP; cnt_n = CW'(GAP_UNITS - 1);
        end else begin
          state_n = S_CONV_HI; cnt_n = cnt_q - CW'(1);
        end
      end
      S_SETUP: if (tick) begin
        if (cnt_q == '0) begin
          state_n = S_CLK_LO; cnt_n = CW'(FRAME_LEN - 1);
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
      S_CLK_LO: if (tick) begin
        sample_en = 1'b1; state_n = S_CLK_HI;
      end
      S_CLK_HI: if (tick) begin
        if (cnt_q == '0) begin
          frame_done = 1'b1; state_n = S_GAP; cnt_n = CW'(GAP_UNITS - 1);
        end else begin
          state_n = S_CLK_LO; cnt_n = cnt_q - CW'(1);
        end
      end
      S_WAKE_HI: if (tick) begin
        state_n = S_GAP; cnt_n = CW'(GAP_UNITS - 1);
      end
      S_GAP: if (tick) begin
        if (cnt_q == '0) state_n = S_IDLE;
        else             cnt_n = cnt_q - CW'(1);
      end
      default: state_n = S_IDLE;
    endcase
    pend_n = (pend_q & ~launch) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_CAP;
      cnt_q   <= '0;
      pend_q  <= '0;
      conv_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      op_q    <= op_n;
      cnt_q   <= cnt_n;
      pend_q  <= pend_n;
      conv_q  <= (state_n == S_CONV_HI);
      sclk_q  <= (state_n == S_CLK_HI) || (state_n == S_WAKE_HI);
    end
  end

  // Start line and clock are never high together (R8 R9 clock held low)
  p_conv_sclk_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_q && sclk_q));
  // A wake operation leaves the start line alone
  p_wake_no_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op_q == OP_WAKE) |-> !conv_q);
  // Held requests survive a busy cycle
  p_pend_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // The first clock rise of a capture never coincides with the start strobe
  p_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op_q == OP_CAP && $rose(sclk_q)) |-> !$past(conv_q));
endmodule

// File: rtl/acc_frame_pack.sv
module acc_frame_pack
  import acc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                din,
  input  logic                frame_done,
  input  logic                signed_fmt,
  output logic [OUT_BITS-1:0] result_o,
  output logic                valid_o,
  output logic                notrdy_o
);
  logic [WORD_BITS-1:0] sh_q, sh_n;
  logic [OUT_BITS-1:0]  res_q, res_n, fmt_word;
  logic                 valid_q, notrdy_q;
  logic                 rdy_bit;

  assign rdy_bit = sh_q[WORD_BITS-1];

  always_comb begin
    if (signed_fmt)
      fmt_word = {{(OUT_BITS-DATA_BITS){sh_q[DATA_BITS-1]}}, sh_q[DATA_BITS-1:0]};
    else
      fmt_word = {{(OUT_BITS-WORD_BITS){1'b0}}, sh_q};
    sh_n  = sample_en  ? {sh_q[WORD_BITS-2:0], din} : sh_q;
    res_n = frame_done ? fmt_word : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      res_q    <= '0;
      valid_q  <= 1'b0;
      notrdy_q <= 1'b0;
    end else begin
      sh_q     <= sh_n;
      res_q    <= res_n;
      valid_q  <= frame_done;
      notrdy_q <= frame_done && !rdy_bit;
    end
  end

  assign result_o = res_q;
  assign valid_o  = valid_q;
  assign notrdy_o = notrdy_q;

  p_notrdy_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    notrdy_q |-> valid_q);
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import acc_pkg::*;
#(
  parameter int DIV_CYC     = 10,
  parameter int SETUP_UNITS = 2,
  parameter int GAP_UNITS   = 5,
  parameter int FRAME_LEN   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_req,
  input  logic        nap_req,
  input  logic        sleep_req,
  input  logic        wake_req,
  input  logic        bipolar_i,
  input  logic        sext_i,
  input  logic        adc_dout,
  output logic        adc_conv,
  output logic        adc_sclk,
  output logic [15:0] sample_o,
  output logic        sample_valid_o,
  output logic        not_ready_o
);
  logic rs1_q, rs2_q;
  logic run, tick, sample_en, frame_done;
  logic [NREQ-1:0] req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  always_comb begin
    req           = '0;
    req[BIT_CAP]  = cap_req;
    req[BIT_NAP]  = nap_req;
    req[BIT_SLP]  = sleep_req;
    req[BIT_WAKE] = wake_req;
  end

  acc_tick_gen #(.DIV_CYC(DIV_CYC)) u_tick (
    .clk(clk), .rst_n(rs2_q), .run(run), .tick(tick)
  );

  acc_seq #(
    .SETUP_UNITS(SETUP_UNITS), .GAP_UNITS(GAP_UNITS), .FRAME_LEN(FRAME_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rs2_q), .tick(tick), .req(req), .run(run),
    .conv_o(adc_conv), .sclk_o(adc_sclk),
    .sample_en(sample_en), .frame_done(frame_done)
  );

  acc_frame_pack u_pack (
    .clk(clk), .rst_n(rs2_q), .sample_en(sample_en), .din(adc_dout),
    .frame_done(frame_done), .signed_fmt(bipolar_i && sext_i),
    .result_o(sample_o), .valid_o(sample_valid_o), .notrdy_o(not_ready_o)
  );

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rs2_q)
    (sample_valid_o && !(bipolar_i && sext_i)) |-> (sample_o[15:13] == 3'b000));
  p_sext_r6: assert property (@(posedge clk) disable iff (!rs2_q)
    (sample_valid_o && bipolar_i && sext_i) |-> (sample_o[15:12] == {4{sample_o[11]}}));
endmodule

// File: tb/tb_adc_capture_ctrl.sv
module tb_adc_capture_ctrl;
  localparam int DIV   = 10;
  localparam int SETUP = 2;
  localparam int GAP   = 5;
  localparam int FLEN  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_req = 0, nap_req = 0, sleep_req = 0, wake_req = 0;
  logic bipolar_i = 0, sext_i = 0, adc_dout = 0;
  logic adc_conv, adc_sclk, sample_valid_o, not_ready_o;
  logic [15:0] sample_o;

  always #4 clk = ~clk;

  adc_capture_ctrl #(.DIV_CYC(DIV), .SETUP_UNITS(SETUP), .GAP_UNITS(GAP), .FRAME_LEN(FLEN)) dut (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .nap_req(nap_req),
    .sleep_req(sleep_req), .wake_req(wake_req), .bipolar_i(bipolar_i),
    .sext_i(sext_i), .adc_dout(adc_dout), .adc_conv(adc_conv),
    .adc_sclk(adc_sclk), .sample_o(sample_o),
    .sample_valid_o(sample_valid_o), .not_ready_o(not_ready_o)
  );

  int errors = 0, checks = 0, cyc = 0;
  logic [15:0] frame = 16'h0;

  // reference model: per-clock expected line values; bit0 conv, bit1 sclk, bit2 valid
  int q[$];
  logic [3:0] pm = 4'h0;
  int sync_cnt = 0;
  int cur = 0;

  task automatic push_n(input int code, input int n);
    for (int i = 0; i < n; i++) q.push_back(code);
  endtask

  task automatic push_gap(input bit with_valid);
    push_n(with_valid ? 4 : 0, 1);
    push_n(0, GAP * DIV - 1);
    push_n(0, 1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); pm = 0; sync_cnt = 0; cur = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++; cur = 0;
    end else begin
      if (q.size() == 0 && pm != 0) begin
        if (pm[3]) begin
          pm[3] = 0; push_n(2, DIV); push_gap(0);
        end else if (pm[2] || pm[1]) begin
          int np;
          np = pm[2] ? 4 : 2;
          if (pm[2]) pm[2] = 0; else pm[1] = 0;
          for (int k = 0; k < np; k++) begin push_n(1, DIV); push_n(0, DIV); end
          push_gap(0);
        end else begin
          pm[0] = 0;
          push_n(1, DIV); push_n(0, SETUP * DIV);
          for (int k = 0; k < FLEN; k++) begin push_n(0, DIV); push_n(2, DIV); end
          push_gap(1);
        end
      end
      pm = pm | {wake_req, sleep_req, nap_req, cap_req};
      cur = (q.size() > 0) ? q.pop_front() : 0;
    end
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    if (bipolar_i && sext_i) return {{4{frame[11]}}, frame[11:0]};
    return {3'b000, frame[12:0]};
  endfunction

  // monitors and converter model
  logic pconv = 0, psclk = 0;
  int idx = 0;
  int cr = 0, sr = 0, vc = 0, last_fall = 0, gap_meas = 0, first_after_valid = 0;

  always @(negedge clk) begin
    cyc++;
    if (sync_cnt >= 2 && rst_n) begin
      // R2 R3 R8 R9 R10 R11 R12: per-clock line comparison against the model
      check(adc_conv == cur[0] && adc_sclk == cur[1] && sample_valid_o == cur[2] &&
            (cur[2] || !not_ready_o), "R2 R3 R7 R8 R9 R10", "lines conv/sclk/valid/nrdy",
            {adc_conv, adc_sclk, sample_valid_o, not_ready_o},
            {cur[0], cur[1], cur[2], 1'b0});
      if (cur[2]) begin
        check(sample_o == exp_word(), "R4 R5 R6", "result", sample_o, exp_word());
        check(not_ready_o == !frame[12], "R7", "not-ready", not_ready_o, !frame[12]);
      end
    end
    if (adc_conv && !pconv) begin cr++; idx = 0; if (first_after_valid == 0 && vc > 0) first_after_valid = 2; end
    if (!adc_conv && pconv) last_fall = cyc;
    if (adc_sclk && !psclk) begin
      sr++; idx++;
      if (first_after_valid == 0 && vc > 0) first_after_valid = 1;
      gap_meas = cyc - last_fall;
    end
    if (sample_valid_o) vc++;
    adc_dout = (idx < 16) ? frame[15 - idx] : 1'b0;
    pconv = adc_conv; psclk = adc_sclk;
  end

  task automatic clr_mon();
    cr = 0; sr = 0; vc = 0; first_after_valid = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cap_req = 1; 1: nap_req = 1; 2: sleep_req = 1; default: wake_req = 1;
    endcase
    @(negedge clk);
    cap_req = 0; nap_req = 0; sleep_req = 0; wake_req = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (q.size() != 0 || pm != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic capture(input logic [15:0] f, input logic bip, input logic sx);
    frame = f; bipolar_i = bip; sext_i = sx;
    clr_mon();
    pulse(0);
    wait_idle();
    check(sr == FLEN, "R3", "clock pulses per capture", sr, FLEN);
    check(cr == 1, "R2", "start pulses per capture", cr, 1);
    check(vc == 1, "R7", "valid strobes", vc, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!adc_conv && !adc_sclk && !sample_valid_o && !not_ready_o && sample_o == 0,
          "R1", "reset state", {adc_conv, adc_sclk, sample_valid_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!adc_conv && !adc_sclk && sample_o == 0, "R1", "after release", sample_o, 0);

    // R4 R5: plain format, ready high, leading junk bits discarded
    capture(16'b101_1_1010_0101_1100, 0, 0);
    check(sample_o == 16'h1A5C, "R5", "plain word", sample_o, 16'h1A5C);
    // R7: ready low
    capture(16'b011_0_0011_1100_0001, 0, 0);
    check(sample_o == 16'h03C1, "R7", "not-ready capture word", sample_o, 16'h03C1);
    // R6: signed negative, signed positive, sext without bipolar
    capture(16'b000_1_1000_0000_0000, 1, 1);
    check(sample_o == 16'hF800, "R6", "sext negative", sample_o, 16'hF800);
    capture(16'b111_1_0111_1111_1111, 1, 1);
    check(sample_o == 16'h07FF, "R6", "sext positive", sample_o, 16'h07FF);
    capture(16'b000_1_1111_0000_1111, 0, 1);
    check(sample_o == 16'h1F0F, "R6", "sext ignored in unipolar", sample_o, 16'h1F0F);

    // R8 light power-down
    clr_mon(); pulse(1); wait_idle();
    check(cr == 2 && sr == 0, "R8", "nap pulses/clocks", {cr[7:0], sr[7:0]}, 16'h0200);
    // R9 deep power-down
    clr_mon(); pulse(2); wait_idle();
    check(cr == 4 && sr == 0, "R9", "sleep pulses/clocks", {cr[7:0], sr[7:0]}, 16'h0400);
    // R10 wake
    clr_mon(); pulse(3); wait_idle();
    check(cr == 0 && sr == 1, "R10", "wake pulses/clocks", {cr[7:0], sr[7:0]}, 16'h0001);

    // R11 quiet interval: wake requested during deep power-down
    clr_mon(); pulse(2); repeat (5) @(negedge clk); pulse(3); wait_idle();
    check(gap_meas == DIV * (1 + GAP) + 1, "R11", "start fall to wake rise",
          gap_meas, DIV * (1 + GAP) + 1);
    check(cr == 4 && sr == 1, "R12", "held wake served", {cr[7:0], sr[7:0]}, 16'h0401);

    // R12: requests during a capture held, then served wake first
    frame = 16'b000_1_0000_1111_0000; bipolar_i = 0; sext_i = 0;
    clr_mon(); pulse(0); repeat (20) @(negedge clk);
    pulse(1); pulse(2); pulse(3);
    wait_idle();
    check(cr == 7 && sr == FLEN + 1 && vc == 1, "R12", "all held requests served",
          {cr[7:0], sr[7:0]}, {8'd7, 8'(FLEN + 1)});
    check(first_after_valid == 1, "R12", "wake served before power-down", first_after_valid, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule